// File: doc/BRIEF.md
# Speculative Load Guard

The guard inspects a non-excepting (speculative) load before it reaches memory. It forms the effective address from a base register value plus either an index register value or an immediate. It then checks that address, and the destination register number, against the alignment that the access size demands. An alignment problem does not raise a trap. Instead, the guard marks the destination register as carrying a deferred fault in a 64-entry flag vector. There is one vector for integer registers and one for floating-point registers.

When a load finds no alignment problem, the guard passes poison from its sources to its destination. If the base register, or the index register when indexing is used, already carries a deferred fault, the destination inherits the mark and the load is told not to proceed. Otherwise the destination's mark is cleared.

When the control inputs enable recording, each accepted load claims the lowest free entry of a small bank of fault records. That entry stores a description of the load and its effective address, so that a later recovery step can replay it. Memory access itself lies outside the block. Each request is accepted in one cycle, and its response appears on the registered outputs one cycle later.

Top module: `spec_load_guard`

## Requirements
- R1: The effective address is `req_base + req_index` when `req_use_index` is 1 and `req_base + req_imm` otherwise, modulo 2^AW. It is the address stored with an allocated record.
- R2: Size codes are 0 signed byte, 1 unsigned byte, 2 signed half, 3 unsigned half, 4 word, 5 double and 6 quad. Address alignment is checked per size: bytes never fault, halves fault on a nonzero address bit 0, words on nonzero bits 1:0, doubles on nonzero bits 2:0, and quads on nonzero bits 3:0.
- R3: A double faults when the target register number is odd. A quad faults when bits 1:0 of the target register number are nonzero.
- R4: When any alignment fault is found, `rsp_fault` is 1, `rsp_proceed` is 1 and the target register's flag is set.
- R5: Without a fault, the target flag becomes the OR of the base register's flag and, only when `req_use_index` is 1, the index register's flag. `rsp_proceed` is 0 exactly when that OR is 1.
- R6: Loads with `req_fp` = 1 read and write only `flags_fp`. Loads with `req_fp` = 0 read and write only `flags_int`.
- R7: A record is written only when `ctl_valid` and `ctl_rec_en` are both 1.
- R8: The record written is the lowest-indexed record that is not valid and whose index is below `ctl_count`. Its word, from MSB to LSB, holds: valid=1, address-valid=1, fp flag, address-fault bit, register-fault bit, its own index (IW bits), size code (3 bits) and target register number (RW bits, at the LSB).
- R9: When recording is active and no record qualifies, `rsp_ovf` is 1 and no record changes. The flag update still happens.
- R10: Size code 7 is illegal. It gives `rsp_size_err` = 1, with `rsp_proceed`, `rsp_fault` and `rsp_ovf` all 0, and it changes no flag and no record.
- R11: After reset, all flags, all records, their addresses and all response outputs are 0.
- R12: Responses appear one cycle after `req_valid`. In a cycle without `req_valid`, no flag changes and `rsp_valid` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A load is presented this cycle |
| req_base | input | AW | Base register value |
| req_index | input | AW | Index register value |
| req_imm | input | AW | Immediate displacement |
| req_use_index | input | 1 | 1: add the index register, 0: add the immediate |
| req_base_reg | input | RW | Base register number |
| req_index_reg | input | RW | Index register number |
| req_tgt_reg | input | RW | Destination register number |
| req_size | input | 3 | Access size code |
| req_fp | input | 1 | Destination is a floating-point register |
| ctl_valid | input | 1 | Control setting is valid |
| ctl_rec_en | input | 1 | Recording enable |
| ctl_count | input | CW | Number of records available for use |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_proceed | output | 1 | Load may be performed |
| rsp_fault | output | 1 | Alignment fault detected |
| rsp_size_err | output | 1 | Illegal size code |
| rsp_ovf | output | 1 | Recording active but no record free |
| flags_int | output | NREGS | Integer deferred-fault flags |
| flags_fp | output | NREGS | Floating-point deferred-fault flags |
| rec_sel | input | IW | Record read select |
| rec_word | output | REC_W | Selected record word |
| rec_addr | output | AW | Selected record's stored address |

## Verification
Some rules are checked on every cycle. A fault or a suppressed load always leaves the target flag set in the right class. An illegal size never comes with any other response bit. Idle cycles leave both flag vectors untouched. An overflow is never reported with recording disabled.

The bench scenarios are needed to show the other behaviour. These are the exact address and register alignment limits per size, and propagation through the base register versus the index register. They also cover lowest-free record selection under a changing count limit, the stored record contents and address, and the recovery of all state after reset.

// File: rtl/slg_pkg.sv
package slg_pkg;

   typedef enum logic [2:0] {
      SZ_S8   = 3'd0,
      SZ_U8   = 3'd1,
      SZ_S16  = 3'd2,
      SZ_U16  = 3'd3,
      SZ_W32  = 3'd4,
      SZ_D64  = 3'd5,
      SZ_Q128 = 3'd6,
      SZ_BAD  = 3'd7
   } slg_size_e;

   // Low address bits that must be zero for a given access size
   function automatic logic [3:0] addr_mask(input logic [2:0] s);
      case (slg_size_e'(s))
         SZ_S16, SZ_U16: return 4'h1;
         SZ_W32:         return 4'h3;
         SZ_D64:         return 4'h7;
         SZ_Q128:        return 4'hF;
         default:        return 4'h0;
      endcase
   endfunction

   // Low register-number bits that must be zero for multi-register sizes
   function automatic logic [1:0] reg_mask(input logic [2:0] s);
      case (slg_size_e'(s))
         SZ_D64:  return 2'b01;
         SZ_Q128: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic size_legal(input logic [2:0] s);
      return slg_size_e'(s) != SZ_BAD;
   endfunction

endpackage

// File: rtl/slg_align.sv
module slg_align #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] index,
   input  logic [AW-1:0] imm,
   input  logic          use_index,
   input  logic [2:0]    size,
   input  logic [1:0]    tgt_lo,
   output logic [AW-1:0] eff_addr,
   output logic          addr_fault,
   output logic          reg_fault,
   output logic          legal
);
   import slg_pkg::*;

   if (AW < 4) begin : g_aw_check
      $error("slg_align: AW must be at least 4");
   end

   logic [AW-1:0] offset;

   always_comb begin
      offset     = use_index ? index : imm;
      eff_addr   = base + offset;
      legal      = size_legal(size);
      addr_fault = legal && ((eff_addr[3:0] & addr_mask(size)) != 4'h0);
      reg_fault  = legal && ((tgt_lo & reg_mask(size)) != 2'b00);
   end

endmodule

// File: rtl/slg_flags.sv
module slg_flags #(
   parameter int NREGS = 64,
   parameter int RW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic             upd_fp,
   input  logic [RW-1:0]    upd_reg,
   input  logic             upd_val,
   input  logic             rd_fp,
   input  logic [RW-1:0]    rd_a_reg,
   input  logic [RW-1:0]    rd_b_reg,
   output logic             rd_a,
   output logic             rd_b,
   output logic [NREGS-1:0] flags_int,
   output logic [NREGS-1:0] flags_fp
);

   if (NREGS != (1 << RW)) begin : g_size_check
      $error("slg_flags: NREGS must equal 2**RW");
   end

   // one flag vector per register class: 0 integer, 1 floating point
   for (genvar g = 0; g < 2; g++) begin : g_class
      localparam logic CLS = (g == 1);
      logic [NREGS-1:0] v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            v <= '0;
         else if (upd_en && (upd_fp == CLS))
            v[upd_reg] <= upd_val;
      end
   end

   assign flags_int = g_class[0].v;
   assign flags_fp  = g_class[1].v;
   assign rd_a = rd_fp ? flags_fp[rd_a_reg] : flags_int[rd_a_reg];
   assign rd_b = rd_fp ? flags_fp[rd_b_reg] : flags_int[rd_b_reg];

endmodule

// File: rtl/slg_records.sv
module slg_records #(
   parameter int NREC  = 4,
   parameter int AW    = 32,
   parameter int RW    = 6,
   parameter int IW    = 2,
   parameter int CW    = 3,
   parameter int REC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [CW-1:0]    ctl_count,
   input  logic [RW-1:0]    f_dst,
   input  logic [2:0]       f_size,
   input  logic             f_fp,
   input  logic             f_afault,
   input  logic             f_rfault,
   input  logic [AW-1:0]    f_addr,
   input  logic [IW-1:0]    rd_sel,
   output logic [REC_W-1:0] rd_word,
   output logic [AW-1:0]    rd_addr,
   output logic             overflow
);

   if (REC_W != 5 + IW + 3 + RW) begin : g_width_check
      $error("slg_records: REC_W does not match the field layout");
   end

   logic [REC_W-1:0] words [NREC];
   logic [AW-1:0]    addrs [NREC];
   logic [IW-1:0]    pick;
   logic             found;
   logic             alloc;

   // lowest invalid record below the usable count
   always_comb begin
      pick  = '0;
      found = 1'b0;
      for (int i = 0; i < NREC; i++) begin
         if (!found && !words[i][REC_W-1] && (i < int'(ctl_count))) begin
            pick  = IW'(i);
            found = 1'b1;
         end
      end
   end

   assign alloc    = wr_req && found;
   assign overflow = wr_req && !found;

   for (genvar i = 0; i < NREC; i++) begin : g_rec
      logic [REC_W-1:0] w_q;
      logic [AW-1:0]    a_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
            a_q <= '0;
         end else if (alloc && (pick == IW'(i))) begin
            w_q <= {1'b1, 1'b1, f_fp, f_afault, f_rfault, IW'(i), f_size, f_dst};
            a_q <= f_addr;
         end
      end
      assign words[i] = w_q;
      assign addrs[i] = a_q;
   end

   always_comb begin
      rd_word = '0;
      rd_addr = '0;
      if (int'(rd_sel) < NREC) begin
         rd_word = words[rd_sel];
         rd_addr = addrs[rd_sel];
      end
   end

endmodule

// File: rtl/spec_load_guard.sv
module spec_load_guard #(
   parameter int AW    = 32,
   parameter int NREGS = 64,
   parameter int NREC  = 4,
   localparam int RW    = $clog2(NREGS),
   localparam int IW    = (NREC > 1) ? $clog2(NREC) : 1,
   localparam int CW    = $clog2(NREC + 1),
   localparam int REC_W = 5 + IW + 3 + RW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [AW-1:0]    req_base,
   input  logic [AW-1:0]    req_index,
   input  logic [AW-1:0]    req_imm,
   input  logic             req_use_index,
   input  logic [RW-1:0]    req_base_reg,
   input  logic [RW-1:0]    req_index_reg,
   input  logic [RW-1:0]    req_tgt_reg,
   input  logic [2:0]       req_size,
   input  logic             req_fp,
   input  logic             ctl_valid,
   input  logic             ctl_rec_en,
   input  logic [CW-1:0]    ctl_count,
   output logic             rsp_valid,
   output logic             rsp_proceed,
   output logic             rsp_fault,
   output logic             rsp_size_err,
   output logic             rsp_ovf,
   output logic [NREGS-1:0] flags_int,
   output logic [NREGS-1:0] flags_fp,
   input  logic [IW-1:0]    rec_sel,
   output logic [REC_W-1:0] rec_word,
   output logic [AW-1:0]    rec_addr
);

   if (NREC < 1) begin : g_nrec_check
      $error("spec_load_guard: NREC must be at least 1");
   end
   if (RW < 2) begin : g_rw_check
      $error("spec_load_guard: NREGS must be at least 4");
   end

   logic [AW-1:0] eff_addr;
   logic          addr_fault, reg_fault, legal;
   logic          src_a, src_b, src_flag, any_fault;
   logic          upd_en, rec_wr, ovf, go;

   slg_align #(.AW(AW)) u_align (
      .base       (req_base),
      .index      (req_index),
      .imm        (req_imm),
      .use_index  (req_use_index),
      .size       (req_size),
      .tgt_lo     (req_tgt_reg[1:0]),
      .eff_addr   (eff_addr),
      .addr_fault (addr_fault),
      .reg_fault  (reg_fault),
      .legal      (legal)
   );

   always_comb begin
      any_fault = addr_fault | reg_fault;
      src_flag  = src_a | (req_use_index & src_b);
      upd_en    = req_valid & legal;
      rec_wr    = upd_en & ctl_valid & ctl_rec_en;
      go        = legal & (any_fault | ~src_flag);
   end

   slg_flags #(.NREGS(NREGS), .RW(RW)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_en    (upd_en),
      .upd_fp    (req_fp),
      .upd_reg   (req_tgt_reg),
      .upd_val   (any_fault | src_flag),
      .rd_fp     (req_fp),
      .rd_a_reg  (req_base_reg),
      .rd_b_reg  (req_index_reg),
      .rd_a      (src_a),
      .rd_b      (src_b),
      .flags_int (flags_int),
      .flags_fp  (flags_fp)
   );

   slg_records #(
      .NREC(NREC), .AW(AW), .RW(RW), .IW(IW), .CW(CW), .REC_W(REC_W)
   ) u_recs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (rec_wr),
      .ctl_count (ctl_count),
      .f_dst     (req_tgt_reg),
      .f_size    (req_size),
      .f_fp      (req_fp),
      .f_afault  (addr_fault),
      .f_rfault  (reg_fault),
      .f_addr    (eff_addr),
      .rd_sel    (rec_sel),
      .rd_word   (rec_word),
      .rd_addr   (rec_addr),
      .overflow  (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_proceed  <= 1'b0;
         rsp_fault    <= 1'b0;
         rsp_size_err <= 1'b0;
         rsp_ovf      <= 1'b0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_proceed  <= req_valid & go;
         rsp_fault    <= upd_en & any_fault;
         rsp_size_err <= req_valid & ~legal;
         rsp_ovf      <= ovf;
      end
   end

endmodule

// File: rtl/spec_load_guard_sva.sv
module spec_load_guard_sva #(
   parameter int NREGS = 64,
   localparam int RW = $clog2(NREGS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [RW-1:0]    req_tgt_reg,
   input logic             req_fp,
   input logic             ctl_valid,
   input logic             ctl_rec_en,
   input logic             rsp_valid,
   input logic             rsp_proceed,
   input logic             rsp_fault,
   input logic             rsp_size_err,
   input logic             rsp_ovf,
   input logic [NREGS-1:0] flags_int,
   input logic [NREGS-1:0] flags_fp
);

   // R10
   size_err_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_size_err |-> (!rsp_proceed && !rsp_fault && !rsp_ovf));

   // R4
   fault_marks_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |->
      ($past(req_fp) ? flags_fp[$past(req_tgt_reg)] : flags_int[$past(req_tgt_reg)]));

   // R5
   suppress_marks_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_proceed && !rsp_size_err) |->
      ($past(req_fp) ? flags_fp[$past(req_tgt_reg)] : flags_int[$past(req_tgt_reg)]));

   // R12
   idle_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(flags_int) && $stable(flags_fp) && !rsp_valid));

   // R6
   fp_leaves_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_fp) |=> $stable(flags_int));

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ovf |-> $past(ctl_valid && ctl_rec_en));

endmodule

bind spec_load_guard spec_load_guard_sva #(.NREGS(NREGS)) u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_tgt_reg  (req_tgt_reg),
   .req_fp       (req_fp),
   .ctl_valid    (ctl_valid),
   .ctl_rec_en   (ctl_rec_en),
   .rsp_valid    (rsp_valid),
   .rsp_proceed  (rsp_proceed),
   .rsp_fault    (rsp_fault),
   .rsp_size_err (rsp_size_err),
   .rsp_ovf      (rsp_ovf),
   .flags_int    (flags_int),
   .flags_fp     (flags_fp)
);

// File: tb/spec_load_guard_bench.sv
`timescale 1ns/1ps
module spec_load_guard_bench;

   localparam int AW = 32, NREGS = 64, NREC = 4;
   localparam int RW = 6, IW = 2, CW = 3, REC_W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             req_valid, req_use_index, req_fp;
   logic [AW-1:0]    req_base, req_index, req_imm;
   logic [RW-1:0]    req_base_reg, req_index_reg, req_tgt_reg;
   logic [2:0]       req_size;
   logic             ctl_valid, ctl_rec_en;
   logic [CW-1:0]    ctl_count;
   logic             rsp_valid, rsp_proceed, rsp_fault, rsp_size_err, rsp_ovf;
   logic [NREGS-1:0] flags_int, flags_fp;
   logic [IW-1:0]    rec_sel;
   logic [REC_W-1:0] rec_word;
   logic [AW-1:0]    rec_addr;

   spec_load_guard #(.AW(AW), .NREGS(NREGS), .NREC(NREC)) u_spec_load_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
      .req_index(req_index), .req_imm(req_imm), .req_use_index(req_use_index),
      .req_base_reg(req_base_reg), .req_index_reg(req_index_reg),
      .req_tgt_reg(req_tgt_reg), .req_size(req_size), .req_fp(req_fp),
      .ctl_valid(ctl_valid), .ctl_rec_en(ctl_rec_en), .ctl_count(ctl_count),
      .rsp_valid(rsp_valid), .rsp_proceed(rsp_proceed), .rsp_fault(rsp_fault),
      .rsp_size_err(rsp_size_err), .rsp_ovf(rsp_ovf),
      .flags_int(flags_int), .flags_fp(flags_fp),
      .rec_sel(rec_sel), .rec_word(rec_word), .rec_addr(rec_addr)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [REC_W-1:0] recw(input logic fp, input logic af, input logic rf,
                                            input logic [IW-1:0] idx, input logic [2:0] sz,
                                            input logic [RW-1:0] dst);
      return {1'b1, 1'b1, fp, af, rf, idx, sz, dst};
   endfunction

   // drive one request; on return the response is on the outputs
   task automatic do_req(input logic [AW-1:0] b, input logic [AW-1:0] x, input logic [AW-1:0] im,
                         input logic ux, input logic [RW-1:0] br, input logic [RW-1:0] xr,
                         input logic [RW-1:0] tr, input logic [2:0] sz, input logic fp);
      @(negedge clk);
      req_base = b; req_index = x; req_imm = im; req_use_index = ux;
      req_base_reg = br; req_index_reg = xr; req_tgt_reg = tr;
      req_size = sz; req_fp = fp; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] idx;
      logic [31:0] imm;
      logic        use_idx;
      logic [5:0]  breg;
      logic [5:0]  ireg;
      logic [5:0]  treg;
      logic [2:0]  size;
      logic        fp;
      logic        go;
      logic        flt;
      logic        tflag;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t TBL [NV] = '{
      '{32'h100, 32'h0, 32'h4, 1'b0, 6'd0, 6'd0, 6'd5,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 word ok
      '{32'h100, 32'h0, 32'h1, 1'b0, 6'd0, 6'd0, 6'd6,  3'd2, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 half odd
      '{32'h103, 32'h0, 32'h0, 1'b0, 6'd6, 6'd0, 6'd7,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 base poisoned
      '{32'h200, 32'h8, 32'h0, 1'b1, 6'd1, 6'd7, 6'd8,  3'd5, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 index poisoned
      '{32'h200, 32'hF, 32'h8, 1'b0, 6'd1, 6'd7, 6'd9,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 index unused
      '{32'h208, 32'h0, 32'h0, 1'b0, 6'd0, 6'd0, 6'd11, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 double odd reg
      '{32'h300, 32'h0, 32'h8, 1'b0, 6'd0, 6'd0, 6'd12, 3'd6, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 quad addr
      '{32'h310, 32'h0, 32'h0, 1'b0, 6'd0, 6'd0, 6'd14, 3'd6, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 quad reg
      '{32'h320, 32'h0, 32'h0, 1'b0, 6'd0, 6'd0, 6'd16, 3'd6, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 quad ok
      '{32'h400, 32'h0, 32'h2, 1'b0, 6'd0, 6'd0, 6'd20, 3'd4, 1'b0, 1'b1, 1'b1, 1'b1}, // R2 word addr
      '{32'h404, 32'h0, 32'h0, 1'b0, 6'd0, 6'd0, 6'd7,  3'd4, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 clears flag
      '{32'h100, 32'h0, 32'h0, 1'b0, 6'd6, 6'd0, 6'd6,  3'd4, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 fp class
      '{32'h100, 32'h0, 32'h2, 1'b0, 6'd0, 6'd0, 6'd21, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 uhalf ok
      '{32'h104, 32'h0, 32'h1, 1'b0, 6'd0, 6'd0, 6'd22, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 ubyte odd
      '{32'h108, 32'h0, 32'hFFFFFFFC, 1'b0, 6'd0, 6'd0, 6'd23, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0} // R1 wrap
   };

   initial begin
      #(8 * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NREGS-1:0] snap_i, snap_f;
      rst_n = 1'b0; req_valid = 1'b0; req_use_index = 1'b0; req_fp = 1'b0;
      req_base = '0; req_index = '0; req_imm = '0;
      req_base_reg = '0; req_index_reg = '0; req_tgt_reg = '0; req_size = '0;
      ctl_valid = 1'b0; ctl_rec_en = 1'b0; ctl_count = '0; rec_sel = '0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({rsp_valid, rsp_proceed, rsp_fault, rsp_size_err, rsp_ovf}, 0, "R11 rsp");
      chk(flags_int, 0, "R11 flags_int");
      chk(flags_fp, 0, "R11 flags_fp");
      chk(rec_word, 0, "R11 record");
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         do_req(TBL[v].base, TBL[v].idx, TBL[v].imm, TBL[v].use_idx, TBL[v].breg,
                TBL[v].ireg, TBL[v].treg, TBL[v].size, TBL[v].fp);
         chk(rsp_proceed, TBL[v].go, $sformatf("R5 proceed vec %0d", v));
         chk(rsp_fault, TBL[v].flt, $sformatf("R2/R3 fault vec %0d", v));
         chk(TBL[v].fp ? flags_fp[TBL[v].treg] : flags_int[TBL[v].treg],
             TBL[v].tflag, $sformatf("R4 target flag vec %0d", v));
      end
      chk(flags_int[6], 1'b1, "R6 int flag untouched by fp load");
      chk(rec_word, 0, "R7 no record while disabled");

      // R10 illegal size
      snap_i = flags_int; snap_f = flags_fp;
      do_req(32'h100, 0, 0, 1'b0, 6'd6, 6'd0, 6'd30, 3'd7, 1'b0);
      chk(rsp_size_err, 1'b1, "R10 size_err");
      chk({rsp_proceed, rsp_fault, rsp_ovf}, 0, "R10 others low");
      chk(flags_int, snap_i, "R10 flags_int unchanged");
      chk(flags_fp, snap_f, "R10 flags_fp unchanged");

      // recording
      ctl_valid = 1'b1; ctl_rec_en = 1'b1; ctl_count = 3'd3;
      do_req(32'h1000, 0, 32'h4, 1'b0, 6'd0, 6'd0, 6'd11, 3'd5, 1'b0);
      chk(rsp_valid, 1'b1, "R12 response valid");
      rec_sel = 2'd0; #1;
      chk(rec_word, recw(1'b0, 1'b1, 1'b1, 2'd0, 3'd5, 6'd11), "R8 record0");
      chk(rec_addr, 32'h1004, "R1 record0 address");
      @(negedge clk);
      chk(rsp_valid, 1'b0, "R12 no response when idle");

      do_req(32'h1F00, 32'h100, 32'h7, 1'b1, 6'd0, 6'd0, 6'd3, 3'd4, 1'b1);
      rec_sel = 2'd1; #1;
      chk(rec_word, recw(1'b1, 1'b0, 1'b0, 2'd1, 3'd4, 6'd3), "R8 record1");
      chk(rec_addr, 32'h2000, "R1 indexed address");

      ctl_rec_en = 1'b0;
      do_req(32'h3000, 0, 0, 1'b0, 6'd0, 6'd0, 6'd4, 3'd4, 1'b0);
      rec_sel = 2'd2; #1;
      chk(rec_word, 0, "R7 record enable off");
      ctl_rec_en = 1'b1; ctl_valid = 1'b0;
      do_req(32'h3000, 0, 0, 1'b0, 6'd0, 6'd0, 6'd4, 3'd4, 1'b0);
      #1;
      chk(rec_word, 0, "R7 control invalid");
      chk(rsp_ovf, 1'b0, "R9 no overflow when off");

      ctl_valid = 1'b1;
      do_req(32'h3000, 0, 0, 1'b0, 6'd0, 6'd0, 6'd5, 3'd0, 1'b0);
      #1;
      chk(rec_word, recw(1'b0, 1'b0, 1'b0, 2'd2, 3'd0, 6'd5), "R8 record2");

      do_req(32'h3001, 0, 0, 1'b0, 6'd0, 6'd0, 6'd40, 3'd2, 1'b0);
      rec_sel = 2'd3; #1;
      chk(rsp_ovf, 1'b1, "R9 overflow at count limit");
      chk(rec_word, 0, "R9 record3 untouched");
      chk(flags_int[40], 1'b1, "R9 flag still updated");

      ctl_count = 3'd4;
      do_req(32'h4000, 0, 0, 1'b0, 6'd0, 6'd0, 6'd42, 3'd6, 1'b0);
      #1;
      chk(rsp_ovf, 1'b0, "R8 count raised");
      chk(rec_word, recw(1'b0, 1'b0, 1'b1, 2'd3, 3'd6, 6'd42), "R8 record3");
      chk(rec_addr, 32'h4000, "R1 record3 address");

      // R11 reset again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(flags_int, 0, "R11 flags after reset");
      chk(rec_word, 0, "R11 record after reset");
      chk(rec_addr, 0, "R11 address after reset");
      rst_n = 1'b1;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule